// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block collects the interrupt causes of a serial port and reports the most urgent one through a read-only identification register. The receiver, transmitter, FIFO and modem-line logic supply event strobes and levels. The host register decoder supplies one-cycle access strobes. These cover reads of the identification, line status, modem status and receive buffer registers, writes of transmit data, and the receive-FIFO reset.

Each cause is held in a flag. Some flags are sticky and some follow a level. Every flag is gated by its own enable and passed through a fixed priority encoder. The result is registered as a 4-bit identification code with an active-low pending bit in bit 0. An autobaud-lock status sits in bit 4, all higher bits read zero, and a registered interrupt line goes with the code.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_data` reads 0x00000001 (bits 3:0 = 0001, no cause pending) and `irq` is 0.
- R2: A `line_err_evt` pulse latches the line-status cause, code 0110. It has the highest priority and stays until an `rd_lsr` strobe. A read of the identification register does not clear it.
- R3: The received-data cause, code 0100, follows `rx_buf_full` when `fifo_en` is 0 and follows `rx_at_trig` when `fifo_en` is 1. The unused input has no effect.
- R4: A `rx_tmo_evt` pulse with `fifo_en` = 1 latches the timeout cause, code 1100. It is reported ahead of the received-data cause and is cleared by `rd_rbr` or `rx_fifo_rst`. With `fifo_en` = 0 the pulse has no effect.
- R5: A rising edge of `tx_space` latches the transmit-request cause, code 0010, below received data in priority. A `wr_thr` strobe clears it.
- R6: `rd_iir` clears the transmit request only when `iir_data[3:0]` shows 0010 in that cycle. A rising edge of `tx_space` in the same cycle keeps it pending.
- R7: A `modem_chg_evt` pulse latches the modem-status cause, code 0000, which has the lowest priority. An `rd_msr` strobe clears it.
- R8: Bit 4 of `iir_data` mirrors `autobaud_lock`. Bits 31:5 always read 0.
- R9: `irq_en` gates each cause: bit 0 line status, bit 1 received data, bit 2 timeout, bit 3 transmit request, bit 4 modem status. A masked cause is not reported but stays latched, and it appears once its enable returns.
- R10: `irq` is 1 exactly when bit 0 of `iir_data` is 0.
- R11: An input strobe at clock edge N changes `iir_data` and `irq` after edge N+1, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode selected |
| irq_en | input | 5 | Per-cause enables (see R9) |
| line_err_evt | input | 1 | Overrun, parity, framing or break detected |
| rx_buf_full | input | 1 | Receive holding register full (non-FIFO mode) |
| rx_at_trig | input | 1 | Receive FIFO at or above its trigger level |
| rx_tmo_evt | input | 1 | Character timeout detected |
| tx_space | input | 1 | Holding register empty or transmit FIFO half full or less |
| modem_chg_evt | input | 1 | A modem input line changed |
| autobaud_lock | input | 1 | Divisor loaded by automatic baud logic |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| rd_rbr | input | 1 | Receive buffer / FIFO read strobe |
| wr_thr | input | 1 | Transmit data write strobe |
| rx_fifo_rst | input | 1 | Receive FIFO reset strobe |
| iir_data | output | 32 | Registered identification register value |
| irq | output | 1 | Registered interrupt request |

## Verification
The priority encoder is driven with one cause at a time, which shows that each code sits in the right bit pattern. It is then driven with stacked causes: line status over received data, transmit request and modem status, and timeout over received data. Clearing the top cause must expose the next one, which tells the priority order apart from a simple OR. Identification reads are issued while a higher cause hides a pending transmit request, and again in the same cycle as a new transmit edge, which separates the conditional clear from an unconditional one. Mode switches and mask changes show which inputs are ignored and which flags stay latched under a mask.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 5;
  localparam int S_RLS = 0;
  localparam int S_RDA = 1;
  localparam int S_TMO = 2;
  localparam int S_TDR = 3;
  localparam int S_MSR = 4;
  localparam int ID_W  = 4;
  localparam logic [ID_W-1:0] C_NONE = 4'b0001;
  localparam logic [ID_W-1:0] C_RLS  = 4'b0110;
  localparam logic [ID_W-1:0] C_RDA  = 4'b0100;
  localparam logic [ID_W-1:0] C_TMO  = 4'b1100;
  localparam logic [ID_W-1:0] C_TDR  = 4'b0010;
  localparam logic [ID_W-1:0] C_MSR  = 4'b0000;
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_en,
  input  logic            line_err_evt,
  input  logic            rx_buf_full,
  input  logic            rx_at_trig,
  input  logic            rx_tmo_evt,
  input  logic            tx_space,
  input  logic            modem_chg_evt,
  input  logic            rd_iir,
  input  logic            rd_lsr,
  input  logic            rd_msr,
  input  logic            rd_rbr,
  input  logic            wr_thr,
  input  logic            rx_fifo_rst,
  input  logic            iir_shows_tdr,
  output logic [NSRC-1:0] pend
);
  logic rls_q, rda_q, tmo_q, tdr_q, msr_q;
  logic tx_space_d;
  logic tdr_set, tdr_clr;

  assign tdr_set = tx_space & ~tx_space_d;
  assign tdr_clr = wr_thr | (rd_iir & iir_shows_tdr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rls_q      <= 1'b0;
      rda_q      <= 1'b0;
      tmo_q      <= 1'b0;
      tdr_q      <= 1'b0;
      msr_q      <= 1'b0;
      tx_space_d <= 1'b0;
    end else begin
      tx_space_d <= tx_space;
      // line status: sticky, event wins over clear
      if (line_err_evt)     rls_q <= 1'b1;
      else if (rd_lsr)      rls_q <= 1'b0;
      // received data: level follows the mode-selected source
      rda_q <= fifo_en ? (rx_at_trig & ~rx_fifo_rst) : rx_buf_full;
      // timeout: FIFO mode only
      if (!fifo_en)                   tmo_q <= 1'b0;
      else if (rx_tmo_evt)            tmo_q <= 1'b1;
      else if (rd_rbr || rx_fifo_rst) tmo_q <= 1'b0;
      // transmit request: new edge wins over clear
      if (tdr_set)          tdr_q <= 1'b1;
      else if (tdr_clr)     tdr_q <= 1'b0;
      // modem status
      if (modem_chg_evt)    msr_q <= 1'b1;
      else if (rd_msr)      msr_q <= 1'b0;
    end
  end

  always_comb begin
    pend        = '0;
    pend[S_RLS] = rls_q;
    pend[S_RDA] = rda_q;
    pend[S_TMO] = tmo_q;
    pend[S_TDR] = tdr_q;
    pend[S_MSR] = msr_q;
  end

  AST_RLS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rls_q && !rd_lsr) |=> rls_q); // R2
  AST_TMO_FIFO_ONLY: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !tmo_q); // R4
  AST_TDR_IIR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_iir && iir_shows_tdr && !tdr_set) |=> !tdr_q); // R6
  AST_TDR_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
    (tx_space && !$past(tx_space)) |=> tdr_q); // R6
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act,
  output logic [ID_W-1:0] code
);
  always_comb begin
    if (act[S_RLS])      code = C_RLS;
    else if (act[S_TMO]) code = C_TMO;
    else if (act[S_RDA]) code = C_RDA;
    else if (act[S_TDR]) code = C_TDR;
    else if (act[S_MSR]) code = C_MSR;
    else                 code = C_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             line_err_evt,
  input  logic             rx_buf_full,
  input  logic             rx_at_trig,
  input  logic             rx_tmo_evt,
  input  logic             tx_space,
  input  logic             modem_chg_evt,
  input  logic             autobaud_lock,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             rd_rbr,
  input  logic             wr_thr,
  input  logic             rx_fifo_rst,
  output logic [REG_W-1:0] iir_data,
  output logic             irq
);
  localparam int ABL_BIT = ID_W;

  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  act;
  logic [ID_W-1:0]  code;
  logic [REG_W-1:0] iir_nxt;
  logic [REG_W-1:0] iir_q;
  logic             irq_q;
  logic             iir_shows_tdr;

  assign iir_shows_tdr = (iir_q[ID_W-1:0] == C_TDR);

  uart_irq_flags u_flags (
    .clk           (clk),
    .rst           (rst),
    .fifo_en       (fifo_en),
    .line_err_evt  (line_err_evt),
    .rx_buf_full   (rx_buf_full),
    .rx_at_trig    (rx_at_trig),
    .rx_tmo_evt    (rx_tmo_evt),
    .tx_space      (tx_space),
    .modem_chg_evt (modem_chg_evt),
    .rd_iir        (rd_iir),
    .rd_lsr        (rd_lsr),
    .rd_msr        (rd_msr),
    .rd_rbr        (rd_rbr),
    .wr_thr        (wr_thr),
    .rx_fifo_rst   (rx_fifo_rst),
    .iir_shows_tdr (iir_shows_tdr),
    .pend          (pend)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign act[i] = pend[i] & irq_en[i];
  end

  uart_irq_prio u_prio (
    .act  (act),
    .code (code)
  );

  always_comb begin
    iir_nxt               = '0;
    iir_nxt[ID_W-1:0]     = code;
    iir_nxt[ABL_BIT]      = autobaud_lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= REG_W'(C_NONE);
      irq_q <= 1'b0;
    end else begin
      iir_q <= iir_nxt;
      irq_q <= |act;
    end
  end

  assign iir_data = iir_q;
  assign irq      = irq_q;

  AST_IRQ_PIN: assert property (@(posedge clk) disable iff (rst)
    irq_q == ~iir_q[0]); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    iir_q[REG_W-1:ABL_BIT+1] == '0); // R8
endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en, line_err_evt, rx_buf_full, rx_at_trig, rx_tmo_evt;
  logic        tx_space, modem_chg_evt, autobaud_lock;
  logic        rd_iir, rd_lsr, rd_msr, rd_rbr, wr_thr, rx_fifo_rst;
  logic [4:0]  irq_en;
  logic [31:0] iir_data;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .irq_en(irq_en),
    .line_err_evt(line_err_evt), .rx_buf_full(rx_buf_full),
    .rx_at_trig(rx_at_trig), .rx_tmo_evt(rx_tmo_evt), .tx_space(tx_space),
    .modem_chg_evt(modem_chg_evt), .autobaud_lock(autobaud_lock),
    .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_rbr(rd_rbr),
    .wr_thr(wr_thr), .rx_fifo_rst(rx_fifo_rst),
    .iir_data(iir_data), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] exp_iir, input logic exp_irq, input string req);
    n_chk++;
    if (iir_data !== exp_iir || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
               req, iir_data, irq, exp_iir, exp_irq);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fifo_en = 0; line_err_evt = 0; rx_buf_full = 0; rx_at_trig = 0;
    rx_tmo_evt = 0; tx_space = 0; modem_chg_evt = 0; autobaud_lock = 0;
    rd_iir = 0; rd_lsr = 0; rd_msr = 0; rd_rbr = 0; wr_thr = 0;
    rx_fifo_rst = 0; irq_en = 5'b11111;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk(32'h01, 1'b0, "R1");
  endtask

  task automatic t_modem();
    do_reset();
    modem_chg_evt = 1; step(); modem_chg_evt = 0;
    chk(32'h01, 1'b0, "R11");
    step();
    chk(32'h00, 1'b1, "R7");
    rd_msr = 1; step(); rd_msr = 0; step();
    chk(32'h01, 1'b0, "R7");
  endtask

  task automatic t_tx();
    do_reset();
    tx_space = 1; step(); step();
    chk(32'h02, 1'b1, "R5");
    rd_iir = 1; step(); rd_iir = 0; step();
    chk(32'h01, 1'b0, "R6");
    tx_space = 0; step();
    tx_space = 1; step(); step();
    chk(32'h02, 1'b1, "R5");
    wr_thr = 1; step(); wr_thr = 0; step();
    chk(32'h01, 1'b0, "R5");
  endtask

  task automatic t_tx_shadow();
    do_reset();
    line_err_evt = 1; tx_space = 1; step(); line_err_evt = 0; step();
    chk(32'h06, 1'b1, "R2");
    rd_iir = 1; step(); rd_iir = 0; step();
    chk(32'h06, 1'b1, "R2");
    rd_lsr = 1; step(); rd_lsr = 0; step();
    chk(32'h02, 1'b1, "R6");
    tx_space = 0; step();
    tx_space = 1; rd_iir = 1; step(); rd_iir = 0; step();
    chk(32'h02, 1'b1, "R6");
  endtask

  task automatic t_prio();
    do_reset();
    rx_buf_full = 1; tx_space = 1; modem_chg_evt = 1; line_err_evt = 1;
    step(); modem_chg_evt = 0; line_err_evt = 0; step();
    chk(32'h06, 1'b1, "R2");
    rd_lsr = 1; step(); rd_lsr = 0; step();
    chk(32'h04, 1'b1, "R3");
    rx_buf_full = 0; step(); step();
    chk(32'h02, 1'b1, "R5");
    wr_thr = 1; step(); wr_thr = 0; step();
    chk(32'h00, 1'b1, "R7");
  endtask

  task automatic t_fifo();
    do_reset();
    fifo_en = 1; rx_buf_full = 1; step(); step();
    chk(32'h01, 1'b0, "R3");
    rx_buf_full = 0; rx_at_trig = 1; step(); step();
    chk(32'h04, 1'b1, "R3");
    rx_tmo_evt = 1; step(); rx_tmo_evt = 0; step();
    chk(32'h0C, 1'b1, "R4");
    rd_rbr = 1; step(); rd_rbr = 0; step();
    chk(32'h04, 1'b1, "R4");
    rx_tmo_evt = 1; step(); rx_tmo_evt = 0; step();
    chk(32'h0C, 1'b1, "R4");
    rx_fifo_rst = 1; rx_at_trig = 0; step(); rx_fifo_rst = 0; step();
    chk(32'h01, 1'b0, "R4");
    fifo_en = 0; step();
    rx_tmo_evt = 1; step(); rx_tmo_evt = 0; step();
    chk(32'h01, 1'b0, "R4");
    rx_at_trig = 1; step(); step();
    chk(32'h01, 1'b0, "R3");
  endtask

  task automatic t_enable();
    do_reset();
    irq_en = 5'b10111; tx_space = 1; step(); step();
    chk(32'h01, 1'b0, "R9");
    irq_en = 5'b11111; step(); step();
    chk(32'h02, 1'b1, "R9");
    irq_en = 5'b01111; modem_chg_evt = 1; step(); modem_chg_evt = 0;
    wr_thr = 1; step(); wr_thr = 0; step();
    chk(32'h01, 1'b0, "R9");
  endtask

  task automatic t_abl();
    do_reset();
    autobaud_lock = 1; step(); step();
    chk(32'h11, 1'b0, "R8");
    modem_chg_evt = 1; step(); modem_chg_evt = 0; step();
    chk(32'h10, 1'b1, "R10");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: iir=%h irq=%b expected run to complete", iir_data, irq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_modem();
    t_tx();
    t_tx_shadow();
    t_prio();
    t_fifo();
    t_enable();
    t_abl();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule